// File: doc/BRIEF.md
# EDO DRAM Cycle Classifier

This block watches the control strobes of an extended-data-out DRAM interface (row strobe, column strobe, write enable, output enable) with a clock fast enough to see every strobe edge as a change between two samples. It classifies each row-strobe cycle as a read, an early write, a read-modify-write, a row-only refresh, a column-before-row refresh, a test-mode entry or a hidden refresh. It latches the row address on the row-strobe falling edge and the column address on each column-strobe falling edge inside the cycle. It also reports whether a DRAM obeying extended-data-out rules would be driving its data pins.

The classifier serves as the control front end of a DRAM-like slave model or as a protocol monitor on a memory bus. It also counts how long the row strobe stays low and how long it stays high between cycles, and raises flags when either falls outside the configured limits. Strobes are active low and are assumed to be already synchronous to the clock.

Top module: `edo_cycle_monitor`

## Requirements
- R1: After synchronous reset, every output is zero: `cycle_kind` reads 0 (idle), `cycle_done`, `col_strobe`, `dout_en` and both error flags are 0.
- R2: The first sample with `ras_n` low after a high sample, with `cas_n` high, latches `addr` into `row_addr`; the row address stays unchanged until the next such edge. On the first high sample of `ras_n` after a low one, `cycle_done` pulses for exactly one clock and `cycle_kind` shows the class of the ended cycle; a cycle with no column-strobe falling edge is a row-only refresh, code 4.
- R3: If `cas_n` is already low at the row-strobe falling edge, the row address is not latched and the cycle is a column-before-row refresh (code 5) when `we_n` is high, or a test-mode entry (code 6) when `we_n` is low.
- R4: The first column-strobe falling edge of an access cycle makes it a read (code 1) when `we_n` is high, or an early write (code 2) when `we_n` is low; during an early write `dout_en` stays 0 for the whole cycle.
- R5: A falling edge of `we_n` while `cas_n` is low in a read cycle turns the cycle into a read-modify-write (code 3).
- R6: Every falling edge of `cas_n` while `ras_n` was already low latches `addr[COL_W-1:0]` into `col_addr` and pulses `col_strobe` for one clock, so several columns can be taken within one row (page cycles).
- R7: In a read cycle, `dout_en` becomes 1 once `ras_n`, `cas_n` and `oe_n` are all low and stays 1 after `cas_n` rises while `ras_n` remains low (extended data out hold).
- R8: `dout_en` is 0 after any sample with `oe_n` high, and after any sample in which `ras_n` and `cas_n` are both high.
- R9: If `ras_n` falls with `cas_n` held low, `we_n` high and the outputs driven, the cycle is a hidden refresh (code 7) and `dout_en` stays 1 through it.
- R10: `err_ras_long` is 1 while the number of consecutive low samples of `ras_n` exceeds SINGLE_MAX, or PAGE_MAX once the cycle has seen two or more column falling edges.
- R11: `err_pre_short` pulses for one clock at a row-strobe falling edge preceded by fewer than PRE_MIN consecutive high samples of `ras_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address (ADDR_W = larger of ROW_W, COL_W) |
| row_addr | output | ROW_W | Latched row address |
| col_addr | output | COL_W | Latched column address |
| col_strobe | output | 1 | One-clock pulse per column latch |
| cycle_kind | output | 3 | Class of the last ended row cycle |
| cycle_done | output | 1 | One-clock pulse at the end of each row cycle |
| dout_en | output | 1 | Modelled data output drivers on |
| err_ras_long | output | 1 | Row strobe held low too long |
| err_pre_short | output | 1 | Row precharge shorter than the minimum |

## Verification
The bench builds the block with 11-bit row and column addresses, SINGLE_MAX of 6, PAGE_MAX of 12 and PRE_MIN of 3 samples. These small limits put both overlong-row flags and the short-precharge flag within a few clocks, so the exact sample where each flag turns on can be checked on both sides of the threshold. Each cycle class, page column capture, output hold after the column strobe rises and the hidden-refresh hand-over are driven as directed sequences.

// File: rtl/edo_mon_pkg.sv
// Shared types for the EDO cycle classifier.
// Assumes: nothing; pure declarations.
package edo_mon_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE   = 3'd0,
        CYC_READ   = 3'd1,
        CYC_EWRITE = 3'd2,
        CYC_RMW    = 3'd3,
        CYC_ROR    = 3'd4,
        CYC_CBR    = 3'd5,
        CYC_TEST   = 3'd6,
        CYC_HIDDEN = 3'd7
    } cyc_kind_t;

    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_WE  = 2;
    localparam int NUM_TRACKED = 3;

endpackage

// File: rtl/edo_strobe_hist.sv
// Holds the previous sample of each tracked strobe so edges can be found.
// Assumes: strobes are active low and synchronous; reset value is inactive (1).
module edo_strobe_hist #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    for (genvar i = 0; i < N; i++) begin : g_stb
        logic q;
        // Per-strobe history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b1;
            else        q <= lvl[i];
        end
        assign prev[i] = q;
    end
endmodule

// File: rtl/edo_cycle_fsm.sv
// Classifies each row-strobe cycle and latches row and column addresses.
// Assumes: edges are derived from one-sample history; drv_on is the current
// modelled output driver state.
module edo_cycle_fsm
    import edo_mon_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              we_fall,
    input  logic              drv_on,
    input  logic [ADDR_W-1:0] addr,
    output cyc_kind_t         kind_next,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_strobe,
    output logic [2:0]        cycle_kind,
    output logic              cycle_done,
    output logic              page_mode
);
    cyc_kind_t  cur_q, rep_q;
    logic [1:0] ncol_q;
    logic       col_take;

    // Column taken on a CAS fall inside an already-open row.
    assign col_take  = cas_fall && !ras_n && !ras_fall;
    assign page_mode = ncol_q[1];

    // Next cycle class from the strobe edges.
    always_comb begin
        kind_next = cur_q;
        if (ras_fall) begin
            if (cas_n)       kind_next = CYC_ROR;
            else if (!we_n)  kind_next = CYC_TEST;
            else if (drv_on) kind_next = CYC_HIDDEN;
            else             kind_next = CYC_CBR;
        end else if (ras_rise) begin
            kind_next = CYC_IDLE;
        end else if (!ras_n) begin
            if (col_take && cur_q == CYC_ROR)
                kind_next = we_n ? CYC_READ : CYC_EWRITE;
            else if (we_fall && !cas_n && cur_q == CYC_READ)
                kind_next = CYC_RMW;
        end
    end

    // Class register, report register and end-of-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= CYC_IDLE;
            rep_q      <= CYC_IDLE;
            cycle_done <= 1'b0;
        end else begin
            cur_q      <= kind_next;
            cycle_done <= ras_rise;
            if (ras_rise) rep_q <= cur_q;
        end
    end

    // Row and column address capture with column-count tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_addr   <= '0;
            col_addr   <= '0;
            col_strobe <= 1'b0;
            ncol_q     <= 2'd0;
        end else begin
            col_strobe <= col_take;
            if (ras_fall && cas_n) row_addr <= addr[ROW_W-1:0];
            if (col_take)          col_addr <= addr[COL_W-1:0];
            if (ras_fall)
                ncol_q <= 2'd0;
            else if (col_take && ncol_q != 2'd2)
                ncol_q <= ncol_q + 2'd1;
        end
    end

    assign cycle_kind = rep_q;

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !ras_fall) |=> $stable(row_addr)); // R2
    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done); // R2
    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> !$past(ras_n)); // R6
    AST_EW_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == CYC_EWRITE) |-> !drv_on); // R4
endmodule

// File: rtl/edo_out_drive.sv
// Models the EDO data output drivers: on during a read with OE low, held
// after CAS rises, off when RAS and CAS are both high or OE is high.
// Assumes: kind_next is the class being written this clock.
module edo_out_drive
    import edo_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    input  logic      oe_n,
    input  logic      ras_fall,
    input  cyc_kind_t kind_next,
    output logic      dout_en
);
    logic turn_on, drv_d;

    // Read data appears once RAS, CAS and OE are all low.
    assign turn_on = !ras_n && !cas_n && we_n && (kind_next == CYC_READ);

    // Next driver state; a fresh row access always starts tristated.
    always_comb begin
        if (oe_n || (ras_n && cas_n) || (ras_fall && cas_n))
            drv_d = 1'b0;
        else
            drv_d = dout_en || turn_on;
    end

    // Driver state register.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_en <= 1'b0;
        else        dout_en <= drv_d;
    end

    AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n) |-> !dout_en); // R8
    AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ras_n && cas_n) |-> !dout_en); // R8
endmodule

// File: rtl/edo_ras_timer.sv
// Counts RAS low and high samples and flags overlong active time or short
// precharge. Assumes PAGE_MAX >= SINGLE_MAX.
module edo_ras_timer #(
    parameter int SINGLE_MAX = 1000,
    parameter int PAGE_MAX   = 20000,
    parameter int PRE_MIN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic ras_fall,
    input  logic page_mode,
    output logic err_ras_long,
    output logic err_pre_short
);
    localparam int CNT_W = $clog2(PAGE_MAX + 2);
    localparam int PRE_W = $clog2(PRE_MIN + 1);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SINGLE_MAX);
    localparam logic [CNT_W-1:0] LIM_P = CNT_W'(PAGE_MAX);
    localparam logic [PRE_W-1:0] PRE_L = PRE_W'(PRE_MIN);

    logic [CNT_W-1:0] low_q;
    logic [PRE_W-1:0] high_q;

    // Saturating counts of consecutive low and high RAS samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '1;
        end else if (ras_n) begin
            low_q  <= '0;
            if (high_q != '1) high_q <= high_q + 1'b1;
        end else begin
            high_q <= '0;
            if (ras_fall)          low_q <= CNT_W'(1);
            else if (low_q != '1)  low_q <= low_q + 1'b1;
        end
    end

    // Short-precharge pulse at the RAS falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) err_pre_short <= 1'b0;
        else        err_pre_short <= ras_fall && (high_q < PRE_L);
    end

    assign err_ras_long = low_q > (page_mode ? LIM_P : LIM_S);

    AST_PRE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        err_pre_short |-> !$past(ras_n)); // R11
    AST_LONG_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        err_ras_long |-> !$past(ras_n)); // R10
endmodule

// File: rtl/edo_cycle_monitor.sv
// EDO DRAM cycle classifier top: strobe history, cycle classification with
// address capture, output driver model and RAS timing flags.
// Assumes: strobes synchronous to clk, sampled fast enough to see each edge.
module edo_cycle_monitor
    import edo_mon_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 10,
    parameter int SINGLE_MAX = 1000,
    parameter int PAGE_MAX   = 20000,
    parameter int PRE_MIN    = 3,
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_strobe,
    output logic [2:0]        cycle_kind,
    output logic              cycle_done,
    output logic              dout_en,
    output logic              err_ras_long,
    output logic              err_pre_short
);
    logic [NUM_TRACKED-1:0] stb_now, stb_prev;
    logic      ras_fall, ras_rise, cas_fall, we_fall, page_mode;
    cyc_kind_t kind_next;

    assign stb_now[STB_RAS] = ras_n;
    assign stb_now[STB_CAS] = cas_n;
    assign stb_now[STB_WE]  = we_n;

    assign ras_fall = stb_prev[STB_RAS] && !ras_n;
    assign ras_rise = !stb_prev[STB_RAS] && ras_n;
    assign cas_fall = stb_prev[STB_CAS] && !cas_n;
    assign we_fall  = stb_prev[STB_WE]  && !we_n;

    edo_strobe_hist #(.N(NUM_TRACKED)) u_hist (
        .clk(clk), .rst_n(rst_n), .lvl(stb_now), .prev(stb_prev)
    );

    edo_cycle_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
        .we_fall(we_fall), .drv_on(dout_en), .addr(addr),
        .kind_next(kind_next), .row_addr(row_addr), .col_addr(col_addr),
        .col_strobe(col_strobe), .cycle_kind(cycle_kind),
        .cycle_done(cycle_done), .page_mode(page_mode)
    );

    edo_out_drive u_drv (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .ras_fall(ras_fall), .kind_next(kind_next),
        .dout_en(dout_en)
    );

    edo_ras_timer #(.SINGLE_MAX(SINGLE_MAX), .PAGE_MAX(PAGE_MAX),
                    .PRE_MIN(PRE_MIN)) u_tmr (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ras_fall(ras_fall),
        .page_mode(page_mode), .err_ras_long(err_ras_long),
        .err_pre_short(err_pre_short)
    );

    AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> $past(ras_n)); // R2
endmodule

// File: tb/sim_edo_cycle_monitor.sv
module sim_edo_cycle_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [10:0] addr = '0;
    logic [10:0] row_addr, col_addr;
    logic [2:0]  cycle_kind;
    logic col_strobe, cycle_done, dout_en, err_ras_long, err_pre_short;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    edo_cycle_monitor #(.ROW_W(11), .COL_W(11), .SINGLE_MAX(6),
                        .PAGE_MAX(12), .PRE_MIN(3)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .row_addr(row_addr), .col_addr(col_addr),
        .col_strobe(col_strobe), .cycle_kind(cycle_kind),
        .cycle_done(cycle_done), .dout_en(dout_en),
        .err_ras_long(err_ras_long), .err_pre_short(err_pre_short)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample, then wait until the sampling edge has passed.
    task automatic tick(input logic r, input logic c, input logic w,
                        input logic o, input logic [10:0] a);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1, 1, 1, 0, 11'h0);
    endtask

    task automatic t_reset;
        chk("R1 kind", cycle_kind, 0);
        chk("R1 done", cycle_done, 0);
        chk("R1 dout", dout_en, 0);
        chk("R1 strobe", col_strobe, 0);
        chk("R1 errs", {err_ras_long, err_pre_short}, 0);
        chk("R1 row", row_addr, 0);
    endtask

    task automatic t_ror;
        idle(4);
        tick(0, 1, 1, 0, 11'h2A5);
        chk("R2 row latch", row_addr, 'h2A5);
        chk("R11 no short pre", err_pre_short, 0);
        tick(0, 1, 1, 0, 11'h111);
        tick(0, 1, 1, 0, 11'h111);
        chk("R2 row held", row_addr, 'h2A5);
        tick(1, 1, 1, 0, 11'h0);
        chk("R2 done", cycle_done, 1);
        chk("R2 ror kind", cycle_kind, 4);
        tick(1, 1, 1, 0, 11'h0);
        chk("R2 done one clk", cycle_done, 0);
    endtask

    task automatic t_cbr;
        idle(4);
        tick(1, 0, 1, 0, 11'h0F0);
        tick(0, 0, 1, 0, 11'h0F0);
        chk("R3 cbr no row latch", row_addr, 'h2A5);
        tick(0, 0, 1, 0, 11'h0F0);
        tick(1, 0, 1, 0, 11'h0);
        chk("R3 cbr kind", cycle_kind, 5);
        chk("R3 cbr done", cycle_done, 1);
        idle(1);
    endtask

    task automatic t_test;
        idle(4);
        tick(1, 0, 0, 0, 11'h0);
        tick(0, 0, 0, 0, 11'h0);
        tick(0, 0, 0, 0, 11'h0);
        tick(1, 0, 1, 0, 11'h0);
        chk("R3 test kind", cycle_kind, 6);
        idle(1);
    endtask

    task automatic t_read_page;
        idle(4);
        tick(0, 1, 1, 0, 11'h155);
        chk("R7 no drive before cas", dout_en, 0);
        tick(0, 0, 1, 0, 11'h033);
        chk("R6 strobe", col_strobe, 1);
        chk("R6 col", col_addr, 'h033);
        chk("R7 drive", dout_en, 1);
        tick(0, 1, 1, 0, 11'h0);
        chk("R6 strobe one clk", col_strobe, 0);
        chk("R7 edo hold", dout_en, 1);
        tick(0, 0, 1, 0, 11'h044);
        chk("R6 page strobe", col_strobe, 1);
        chk("R6 page col", col_addr, 'h044);
        tick(0, 1, 1, 0, 11'h0);
        tick(1, 1, 1, 0, 11'h0);
        chk("R4 read kind", cycle_kind, 1);
        chk("R8 off ras cas high", dout_en, 0);
    endtask

    task automatic t_oe;
        idle(4);
        tick(0, 1, 1, 0, 11'h010);
        tick(0, 0, 1, 0, 11'h020);
        chk("R7 drive oe", dout_en, 1);
        tick(0, 0, 1, 1, 11'h0);
        chk("R8 oe high off", dout_en, 0);
        tick(1, 1, 1, 0, 11'h0);
    endtask

    task automatic t_ew;
        idle(4);
        tick(0, 1, 1, 0, 11'h012);
        tick(0, 1, 0, 0, 11'h012);
        tick(0, 0, 0, 0, 11'h077);
        chk("R4 ew hiz", dout_en, 0);
        chk("R6 ew col", col_addr, 'h077);
        tick(0, 1, 1, 0, 11'h0);
        chk("R4 ew hiz after", dout_en, 0);
        tick(1, 1, 1, 0, 11'h0);
        chk("R4 ew kind", cycle_kind, 2);
    endtask

    task automatic t_rmw;
        idle(4);
        tick(0, 1, 1, 0, 11'h013);
        tick(0, 0, 1, 0, 11'h014);
        chk("R5 read out first", dout_en, 1);
        tick(0, 0, 1, 1, 11'h0);
        tick(0, 0, 0, 1, 11'h0);
        tick(0, 1, 1, 1, 11'h0);
        tick(1, 1, 1, 0, 11'h0);
        chk("R5 rmw kind", cycle_kind, 3);
    endtask

    task automatic t_hidden;
        idle(4);
        tick(0, 1, 1, 0, 11'h015);
        tick(0, 0, 1, 0, 11'h016);
        tick(1, 0, 1, 0, 11'h0);
        chk("R9 read ended", cycle_kind, 1);
        chk("R9 hold ras high", dout_en, 1);
        for (int i = 0; i < 3; i++) tick(1, 0, 1, 0, 11'h0);
        tick(0, 0, 1, 0, 11'h0);
        chk("R9 hold refresh", dout_en, 1);
        tick(0, 0, 1, 0, 11'h0);
        tick(1, 0, 1, 0, 11'h0);
        chk("R9 hidden kind", cycle_kind, 7);
        chk("R9 still driven", dout_en, 1);
        tick(1, 1, 1, 0, 11'h0);
        chk("R8 off after hidden", dout_en, 0);
    endtask

    task automatic t_long;
        idle(4);
        tick(0, 1, 1, 1, 11'h0);
        for (int i = 0; i < 5; i++) tick(0, 1, 1, 1, 11'h0);
        chk("R10 single at limit", err_ras_long, 0);
        tick(0, 1, 1, 1, 11'h0);
        chk("R10 single over", err_ras_long, 1);
        tick(1, 1, 1, 0, 11'h0);
        chk("R10 cleared", err_ras_long, 0);
        idle(4);
        tick(0, 1, 1, 1, 11'h0);
        tick(0, 0, 1, 1, 11'h1);
        tick(0, 1, 1, 1, 11'h0);
        tick(0, 0, 1, 1, 11'h2);
        for (int i = 0; i < 8; i++) tick(0, 1, 1, 1, 11'h0);
        chk("R10 page at limit", err_ras_long, 0);
        tick(0, 1, 1, 1, 11'h0);
        chk("R10 page over", err_ras_long, 1);
        tick(1, 1, 1, 0, 11'h0);
    endtask

    task automatic t_pre;
        idle(4);
        tick(0, 1, 1, 0, 11'h0);
        tick(1, 1, 1, 0, 11'h0);
        tick(1, 1, 1, 0, 11'h0);
        tick(0, 1, 1, 0, 11'h0);
        chk("R11 short pre", err_pre_short, 1);
        tick(0, 1, 1, 0, 11'h0);
        chk("R11 pulse one clk", err_pre_short, 0);
        for (int i = 0; i < 3; i++) tick(1, 1, 1, 0, 11'h0);
        tick(0, 1, 1, 0, 11'h0);
        chk("R11 exact min ok", err_pre_short, 0);
        tick(1, 1, 1, 0, 11'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_ror();
        t_cbr();
        t_test();
        t_read_page();
        t_oe();
        t_ew();
        t_rmw();
        t_hidden();
        t_long();
        t_pre();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule